// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit stages. Each stage can be cleared, preset from a data word, incremented or held, and every change happens on the rising clock edge. A stage has two count enables. The parallel enable is shared by all stages. The carry enable is chained, and only the carry enable gates the stage's terminal-count flag.

The top level chains a parameterised number of stages into one wide counter. The terminal-count flag of each stage drives the carry enable of the stage above it. Clear, load strobe and parallel enable reach every stage at once. The chain therefore behaves as one binary counter of 4×N bits, and the last stage's terminal count marks the all-ones state of the whole word.

Clear is active low and has priority over the active-low load strobe. A load ignores both count enables. All pins are plain control and data levels with no handshake, because the counter neither accepts nor emits a stream of data.

Top module: `casc_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count_q` becomes all zeros on that edge, whatever the levels of `load_n`, `en_par` and `en_carry`.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `count_q` takes `load_d` on that edge, whatever the levels of both enables.
- R3: When `clr_n` and `load_n` are both 1 and `en_par` and `en_carry` are both 1 at a rising edge, `count_q` increases by one.
- R4: When `clr_n` and `load_n` are both 1 and either enable is 0 at a rising edge, `count_q` keeps its value.
- R5: `term_cnt` is combinational. It responds to `en_carry` within the same cycle without a clock edge, and `en_par` has no effect on it.
- R6: Counting wraps from all ones to all zeros. For a single stage this is 15 to 0.
- R7: Stage k (bits 4k+3..4k) increments only when every stage below it holds 1111 and both enables are 1. The chain therefore counts as one plain binary number of 4×N bits.
- R8: `term_cnt` is 1 exactly when `count_q` is all ones and `en_carry` is 1.
- R9: On a single stage, the sequence clear, load 12, then count reads 13, 14, 15, 0, 1, 2, with `term_cnt` high only at 15. Dropping `en_par` then holds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel-load strobe, active low |
| load_d | input | 4×N_STAGES | Preset value |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_carry | input | 1 | Carry count enable into the lowest stage |
| count_q | output | 4×N_STAGES | Counter state |
| term_cnt | output | 1 | Terminal count of the whole chain |

## Verification
The bench builds two copies of the block. One uses three stages, a 12-bit word, so that carries across the 0x00F→0x010, 0x0FF→0x100 and 0xFFF→0x000 boundaries can be reached in a few cycles by presetting just below them. The other uses a single stage, which reduces the counter to one 4-bit stage. That makes the exact clear, load 12, count to 2 sequence and the same-cycle terminal-count response to the carry enable observable at the ports.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int STAGE_W = 4;
  typedef logic [STAGE_W-1:0] nib_t;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_INC   = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic  clr_n,
  input  logic  load_n,
  input  logic  en_p,
  input  logic  en_t,
  output mode_e mode
);
  always_comb begin
    if (!clr_n)            mode = MODE_CLEAR;
    else if (!load_n)      mode = MODE_LOAD;
    else if (en_p && en_t) mode = MODE_INC;
    else                   mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic load_n,
  input  nib_t d,
  input  logic en_p,
  input  logic en_t,
  output nib_t q,
  output logic tc
);
  mode_e mode;
  nib_t  q_r;

  cnt_mode_dec u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  always_ff @(posedge clk) begin
    case (mode)
      MODE_CLEAR: q_r <= '0;
      MODE_LOAD:  q_r <= d;
      MODE_INC:   q_r <= q_r + 1'b1;
      default:    q_r <= q_r;
    endcase
  end

  assign q  = q_r;
  assign tc = en_t & (&q_r);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
    !$past(clr_n) |-> (q == '0));
  assert_load_R2: assert property (@(posedge clk) disable iff (!armed)
    ($past(clr_n) && !$past(load_n)) |-> (q == $past(d)));
  assert_inc_R3: assert property (@(posedge clk) disable iff (!armed)
    ($past(clr_n) && $past(load_n) && $past(en_p) && $past(en_t))
      |-> (q == nib_t'($past(q) + 1'b1)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!armed)
    ($past(clr_n) && $past(load_n) && !($past(en_p) && $past(en_t)))
      |-> $stable(q));
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int N_STAGES = 3,
  localparam int W = N_STAGES * STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] load_d,
  input  logic         en_par,
  input  logic         en_carry,
  output logic [W-1:0] count_q,
  output logic         term_cnt
);
  logic [N_STAGES:0] carry;
  assign carry[0] = en_carry;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    nib_t q_k;
    cnt_stage u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .d      (load_d[k*STAGE_W +: STAGE_W]),
      .en_p   (en_par),
      .en_t   (carry[k]),
      .q      (q_k),
      .tc     (carry[k+1])
    );
    assign count_q[k*STAGE_W +: STAGE_W] = q_k;
  end

  assign term_cnt = carry[N_STAGES];

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_chain_inc_R7: assert property (@(posedge clk) disable iff (!armed)
    ($past(clr_n) && $past(load_n) && $past(en_par) && $past(en_carry))
      |-> (count_q == W'($past(count_q) + 1'b1)));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!armed)
    ($past(clr_n) && $past(load_n) && $past(en_par) && $past(term_cnt))
      |-> (count_q == '0));
  assert_wide_tc_R8: assert property (@(posedge clk) disable iff (!armed)
    term_cnt |-> ((&count_q) && en_carry));
endmodule

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
  localparam int W0 = 12;
  typedef struct packed {
    logic clr_n; logic load_n; logic ep; logic et;
    logic [11:0] d; logic [11:0] eq; logic etc;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0,1'b0,1'b1,1'b1,12'hABC,12'h000,1'b0}, // R1 clear over load
    '{1'b1,1'b0,1'b0,1'b0,12'hFFE,12'hFFE,1'b0}, // R2 load, enables low
    '{1'b1,1'b1,1'b1,1'b1,12'h000,12'hFFF,1'b1}, // R3 count, R8 tc
    '{1'b1,1'b1,1'b0,1'b1,12'h000,12'hFFF,1'b1}, // R4 hold, R5 ep no effect
    '{1'b1,1'b1,1'b1,1'b0,12'h000,12'hFFF,1'b0}, // R4 hold, R8 carry low
    '{1'b1,1'b1,1'b1,1'b1,12'h000,12'h000,1'b0}, // R6 wrap
    '{1'b1,1'b0,1'b1,1'b1,12'h00F,12'h00F,1'b0}, // R2 load, enables high
    '{1'b1,1'b1,1'b1,1'b1,12'h000,12'h010,1'b0}, // R7 carry into stage 1
    '{1'b1,1'b0,1'b0,1'b1,12'h0FF,12'h0FF,1'b0}, // R2
    '{1'b1,1'b1,1'b1,1'b1,12'h000,12'h100,1'b0}, // R7 carry into stage 2
    '{1'b0,1'b0,1'b1,1'b1,12'h555,12'h000,1'b0}, // R1
    '{1'b1,1'b0,1'b1,1'b1,12'h123,12'h123,1'b0}, // R2
    '{1'b1,1'b1,1'b1,1'b0,12'h000,12'h123,1'b0}, // R4
    '{1'b1,1'b1,1'b0,1'b0,12'h000,12'h123,1'b0}, // R4
    '{1'b1,1'b0,1'b0,1'b0,12'hEFF,12'hEFF,1'b0}, // R2
    '{1'b1,1'b1,1'b1,1'b1,12'h000,12'hF00,1'b0}  // R7 double carry
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic a_clr_n = 1'b1, a_load_n = 1'b1, a_ep = 1'b0, a_et = 1'b0;
  logic [W0-1:0] a_d = '0, a_q;
  logic a_tc;
  logic b_clr_n = 1'b1, b_load_n = 1'b1, b_ep = 1'b0, b_et = 1'b0;
  logic [3:0] b_d = '0, b_q;
  logic b_tc;

  casc_counter #(.N_STAGES(3)) u0 (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .load_d(a_d),
    .en_par(a_ep), .en_carry(a_et), .count_q(a_q), .term_cnt(a_tc));
  casc_counter #(.N_STAGES(1)) u1 (
    .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .load_d(b_d),
    .en_par(b_ep), .en_carry(b_et), .count_q(b_q), .term_cnt(b_tc));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic b_step(input logic c, input logic l, input logic p, input logic t,
                        input logic [3:0] d);
    @(negedge clk);
    b_clr_n = c; b_load_n = l; b_ep = p; b_et = t; b_d = d;
    @(posedge clk); #2;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      a_clr_n = VECS[i].clr_n; a_load_n = VECS[i].load_n;
      a_ep = VECS[i].ep; a_et = VECS[i].et; a_d = VECS[i].d;
      @(posedge clk); #2;
      chk($sformatf("vec%0d q R1-tag", i), 32'(a_q), 32'(VECS[i].eq));
      chk($sformatf("vec%0d tc R8", i), 32'(a_tc), 32'(VECS[i].etc));
    end

    // R1 reset state on both copies
    @(negedge clk); a_clr_n = 0; a_load_n = 0; a_d = 12'hFFF;
    b_step(1'b0, 1'b0, 1'b1, 1'b1, 4'hF);
    chk("R1 u0 cleared", 32'(a_q), 32'h0);
    chk("R1 u1 cleared", 32'(b_q), 32'h0);
    @(negedge clk); a_clr_n = 1; a_load_n = 1; a_ep = 0; a_et = 0;

    // R9 timing sequence on one stage
    b_step(1'b1, 1'b0, 1'b0, 1'b0, 4'd12);
    chk("R9 preset 12", 32'(b_q), 32'd12);
    for (int s = 0; s < 6; s++) begin
      b_step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      chk($sformatf("R9 count step %0d", s), 32'(b_q), 32'((13 + s) % 16));
      chk($sformatf("R9 tc step %0d", s), 32'(b_tc), 32'(((13 + s) % 16) == 15));
    end
    b_step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    chk("R9 hold after enable dropped", 32'(b_q), 32'd2);

    // R5 combinational tc response on a single stage at 15
    b_step(1'b1, 1'b0, 1'b0, 1'b0, 4'hF);
    chk("R5 tc low with carry low", 32'(b_tc), 32'd0);
    #1 b_et = 1'b1; #1;
    chk("R5 tc follows carry same cycle", 32'(b_tc), 32'd1);
    b_ep = 1'b1; #1;
    chk("R5 ep no effect on tc", 32'(b_tc), 32'd1);
    b_et = 1'b0; #1;
    chk("R5 tc drops with carry", 32'(b_tc), 32'd0);
    chk("R4 no edge no change", 32'(b_q), 32'hF);

    // R6 single-stage wrap
    b_step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R6 single stage wrap", 32'(b_q), 32'd0);

    // R7 full-width carry across every stage boundary
    @(negedge clk); a_clr_n = 1; a_load_n = 0; a_d = 12'h7FF; a_ep = 0; a_et = 0;
    @(posedge clk); #2;
    @(negedge clk); a_load_n = 1; a_ep = 1; a_et = 1;
    @(posedge clk); #2;
    chk("R7 carry through two stages", 32'(a_q), 32'h800);
    chk("R8 tc low not all ones", 32'(a_tc), 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule